// File: doc/BRIEF.md
# Yard Ladder Signal Interlocking

This block decides the stop or proceed aspect of the five two-colour signals at one end of a staging yard. The ladder has a main line and a staging lead on the outside, three yard tracks on the inside, a single turnout that sends the main line to yard track 1 or yard track 2, and a crossover pair (a main-side half and a staging-side half) that, when both halves are reversed, sends the main line onto yard track 3 and cuts the staging lead off. Every route passes through the crossover, so a pair whose halves disagree blocks all five signals.

Each signal is worked out in three steps with no clock and no stored state. First the route set by the turnouts is found. Then that route is checked against the direction the dispatcher has given every track on it and against occupancy of the track it leads onto. Last, a dispatcher stop request can force the signal to red. Track and signal index order is fixed: 0 main line, 1 yard track 1, 2 yard track 2, 3 yard track 3, 4 staging lead. Signals 0 and 4 govern moves into the yard (westbound), signals 1 to 3 govern moves out of a yard track (eastbound).

Top module: `yard_ladder_interlock`

## Requirements
- R1: The outputs depend only on the present inputs, with no clock and no state; with every input high, aspect is 5'b01010.
- R2: Turnout encoding is 1 = normal, 0 = reversed; turn_norm[0] is the single turnout, turn_norm[1] the main-side crossover half, turn_norm[2] the staging-side half. Signal 0 routes main line to track 1 (crossover normal, turn_norm[0]=1), to track 2 (crossover normal, turn_norm[0]=0) or to track 3 (crossover reversed).
- R3: Signal 4 routes staging lead to track 3 only when the crossover is normal; with the crossover reversed it shows red.
- R4: Signal 1 routes track 1 to the main line only with crossover normal and turn_norm[0]=1; signal 2 routes track 2 to the main line only with crossover normal and turn_norm[0]=0; signal 3 routes track 3 to the staging lead (crossover normal) or to the main line (crossover reversed). Otherwise red.
- R5: When turn_norm[1] differs from turn_norm[2], all five aspects are red.
- R6: Direction encoding is dir_east bit 1 = eastbound, 0 = westbound. Signals 0 and 4 show proceed only if both the entry track and the destination yard track are westbound; signals 1 to 3 only if both the yard track and the destination outer track are eastbound.
- R7: occ_n bit 0 means occupied. An occupied destination track forces the signal red; occupancy of a track off the route has no effect.
- R8: stop_n bit 0 forces its signal red; stop_n bit 1 leaves the vetted aspect unchanged.
- R9: For each signal red_en_n equals aspect and grn_en_n equals its inverse, so exactly one lamp enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| turn_norm | input | 3 | Turnout positions, 1 = normal |
| dir_east | input | 5 | Assigned track direction, 1 = eastbound |
| occ_n | input | 5 | Track occupancy, 0 = occupied |
| stop_n | input | 5 | Dispatcher stop request per signal, 0 = force red |
| aspect | output | 5 | Signal aspect, 1 = proceed, 0 = stop |
| red_en_n | output | 5 | Red lamp enable, active low |
| grn_en_n | output | 5 | Green lamp enable, active low |

## Verification
The bench goes after crossover halves that disagree, where a design that only looked at one half would clear a signal onto a route that does not exist, and the reversed crossover, where a design that forgot the staging lead is cut off would clear signal 4. It checks occupancy on and off the route, since a design that tested the source track instead of the destination would either block every exit or clear a move onto an occupied track, and it mixes direction bits so a design that checked only one end of a route is caught. A full sweep of every input combination against an independent route table then catches any stray term.

// File: rtl/yli_pkg.sv
package yli_pkg;
  localparam int NUM_TRK = 5;
  localparam int NUM_TO  = 3;
  localparam int TRK_W   = $clog2(NUM_TRK);

  localparam logic [TRK_W-1:0] TRK_MAIN = TRK_W'(0);
  localparam logic [TRK_W-1:0] TRK_Y1   = TRK_W'(1);
  localparam logic [TRK_W-1:0] TRK_Y2   = TRK_W'(2);
  localparam logic [TRK_W-1:0] TRK_Y3   = TRK_W'(3);
  localparam logic [TRK_W-1:0] TRK_STG  = TRK_W'(4);

  typedef struct packed {
    logic             ok;
    logic             inbound;
    logic [TRK_W-1:0] src;
    logic [TRK_W-1:0] dst;
  } route_t;
endpackage

// File: rtl/yli_route_detect.sv
module yli_route_detect
  import yli_pkg::*;
(
  input  logic [NUM_TO-1:0]           turn_norm,
  output route_t [NUM_TRK-1:0]        rt
);
  logic x_norm, x_rev;

  always_comb begin
    x_norm = turn_norm[1] & turn_norm[2];
    x_rev  = ~turn_norm[1] & ~turn_norm[2];

    rt[0].ok      = x_norm | x_rev;
    rt[0].inbound = 1'b1;
    rt[0].src     = TRK_MAIN;
    rt[0].dst     = x_rev ? TRK_Y3 : (turn_norm[0] ? TRK_Y1 : TRK_Y2);

    rt[1].ok      = x_norm & turn_norm[0];
    rt[1].inbound = 1'b0;
    rt[1].src     = TRK_Y1;
    rt[1].dst     = TRK_MAIN;

    rt[2].ok      = x_norm & ~turn_norm[0];
    rt[2].inbound = 1'b0;
    rt[2].src     = TRK_Y2;
    rt[2].dst     = TRK_MAIN;

    rt[3].ok      = x_norm | x_rev;
    rt[3].inbound = 1'b0;
    rt[3].src     = TRK_Y3;
    rt[3].dst     = x_rev ? TRK_MAIN : TRK_STG;

    rt[4].ok      = x_norm;
    rt[4].inbound = 1'b1;
    rt[4].src     = TRK_STG;
    rt[4].dst     = TRK_Y3;
  end
endmodule

// File: rtl/yli_route_vet.sv
module yli_route_vet
  import yli_pkg::*;
(
  input  route_t [NUM_TRK-1:0] rt,
  input  logic [NUM_TRK-1:0]   dir_east,
  input  logic [NUM_TRK-1:0]   occ_n,
  output logic [NUM_TRK-1:0]   vetted
);
  for (genvar i = 0; i < NUM_TRK; i++) begin : g_vet
    logic want_east, dir_ok, clear;
    always_comb begin
      want_east = ~rt[i].inbound;
      dir_ok    = (dir_east[rt[i].src] == want_east) &&
                  (dir_east[rt[i].dst] == want_east);
      clear     = occ_n[rt[i].dst];
      vetted[i] = rt[i].ok & dir_ok & clear;
    end
  end
endmodule

// File: rtl/yli_aspect_drive.sv
module yli_aspect_drive
  import yli_pkg::*;
(
  input  logic [NUM_TRK-1:0] vetted,
  input  logic [NUM_TRK-1:0] stop_n,
  output logic [NUM_TRK-1:0] aspect,
  output logic [NUM_TRK-1:0] red_en_n,
  output logic [NUM_TRK-1:0] grn_en_n
);
  always_comb begin
    aspect   = vetted & stop_n;
    red_en_n = aspect;
    grn_en_n = ~aspect;
  end
endmodule

// File: rtl/yard_ladder_interlock.sv
module yard_ladder_interlock
  import yli_pkg::*;
(
  input  logic [NUM_TO-1:0]  turn_norm,
  input  logic [NUM_TRK-1:0] dir_east,
  input  logic [NUM_TRK-1:0] occ_n,
  input  logic [NUM_TRK-1:0] stop_n,
  output logic [NUM_TRK-1:0] aspect,
  output logic [NUM_TRK-1:0] red_en_n,
  output logic [NUM_TRK-1:0] grn_en_n
);
  route_t [NUM_TRK-1:0] rt;
  logic   [NUM_TRK-1:0] vetted;

  yli_route_detect u_detect (
    .turn_norm (turn_norm),
    .rt        (rt)
  );

  yli_route_vet u_vet (
    .rt       (rt),
    .dir_east (dir_east),
    .occ_n    (occ_n),
    .vetted   (vetted)
  );

  yli_aspect_drive u_drive (
    .vetted   (vetted),
    .stop_n   (stop_n),
    .aspect   (aspect),
    .red_en_n (red_en_n),
    .grn_en_n (grn_en_n)
  );
endmodule

// File: rtl/yli_checker.sv
module yli_checker
  import yli_pkg::*;
(
  input logic [NUM_TO-1:0]  turn_norm,
  input logic [NUM_TRK-1:0] dir_east,
  input logic [NUM_TRK-1:0] occ_n,
  input logic [NUM_TRK-1:0] stop_n,
  input logic [NUM_TRK-1:0] aspect,
  input logic [NUM_TRK-1:0] red_en_n,
  input logic [NUM_TRK-1:0] grn_en_n
);
  always_comb begin
    AST_LAMP_EXCLUSIVE: assert ((red_en_n ^ grn_en_n) == '1); // R9
    AST_STOP_FORCES_RED: assert ((aspect & ~stop_n) == '0); // R8
    AST_XOVER_SPLIT_RED: assert (!(turn_norm[1] != turn_norm[2]) || aspect == '0); // R5
    AST_STAGING_CUT_OFF: assert (turn_norm[1] || turn_norm[2] || !aspect[4]); // R3
    AST_ENTRY_WESTBOUND: assert (!aspect[0] || !dir_east[0]); // R6
    AST_EXIT_EASTBOUND: assert (!aspect[1] || (dir_east[1] && dir_east[0])); // R6
    AST_ENTRY_DEST_CLEAR: assert (!aspect[4] || occ_n[3]); // R7
  end
endmodule

bind yard_ladder_interlock yli_checker u_chk (
  .turn_norm (turn_norm),
  .dir_east  (dir_east),
  .occ_n     (occ_n),
  .stop_n    (stop_n),
  .aspect    (aspect),
  .red_en_n  (red_en_n),
  .grn_en_n  (grn_en_n)
);

// File: tb/sim_yard_ladder_interlock.sv
module sim_yard_ladder_interlock;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [2:0] turn_norm;
  logic [4:0] dir_east, occ_n, stop_n;
  logic [4:0] aspect, red_en_n, grn_en_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  yard_ladder_interlock u0 (
    .turn_norm (turn_norm),
    .dir_east  (dir_east),
    .occ_n     (occ_n),
    .stop_n    (stop_n),
    .aspect    (aspect),
    .red_en_n  (red_en_n),
    .grn_en_n  (grn_en_n)
  );

  // Reference: independent route table. Returns proceed bit per signal.
  function automatic logic [4:0] ref_aspect(input logic [2:0] t, input logic [4:0] d,
                                            input logic [4:0] o, input logic [4:0] s);
    logic [4:0] r = '0;
    case ({t[2], t[1]})
      2'b11: begin // crossover normal
        if (t[0]) begin
          r[0] = !d[0] && !d[1] && o[1];
          r[1] = d[1] && d[0] && o[0];
        end else begin
          r[0] = !d[0] && !d[2] && o[2];
          r[2] = d[2] && d[0] && o[0];
        end
        r[3] = d[3] && d[4] && o[4];
        r[4] = !d[4] && !d[3] && o[3];
      end
      2'b00: begin // crossover reversed
        r[0] = !d[0] && !d[3] && o[3];
        r[3] = d[3] && d[0] && o[0];
      end
      default: r = '0;
    endcase
    return r & s;
  endfunction

  task automatic compare(input string tag, input logic [4:0] exp);
    n_cmp++;
    if (aspect !== exp || red_en_n !== exp || grn_en_n !== ~exp) begin
      n_bad++;
      $display("FAIL %s: turn=%b dir=%b occ=%b stop=%b aspect=%b red=%b grn=%b expected aspect=%b",
               tag, turn_norm, dir_east, occ_n, stop_n, aspect, red_en_n, grn_en_n, exp);
    end
  endtask

  // {turn_norm, dir_east, occ_n, stop_n, expected aspect}
  localparam int NV = 13;
  localparam logic [22:0] VEC [NV] = '{
    {3'b111, 5'b11111, 5'b11111, 5'b11111, 5'b01010}, // R1 all inputs high
    {3'b110, 5'b11111, 5'b11111, 5'b11111, 5'b01100}, // R4 track 2 exit
    {3'b111, 5'b11100, 5'b11111, 5'b11111, 5'b01001}, // R2 main to track 1
    {3'b111, 5'b11100, 5'b11101, 5'b11111, 5'b01000}, // R7 track 1 occupied
    {3'b101, 5'b11111, 5'b11111, 5'b11111, 5'b00000}, // R5 split crossover
    {3'b011, 5'b10110, 5'b11111, 5'b11111, 5'b00000}, // R5 split other way
    {3'b001, 5'b10110, 5'b11111, 5'b11111, 5'b00001}, // R2 main to track 3
    {3'b001, 5'b11111, 5'b11111, 5'b11111, 5'b01000}, // R4 track 3 to main, R3 staging cut
    {3'b111, 5'b11111, 5'b11111, 5'b00000, 5'b00000}, // R8 all stopped
    {3'b111, 5'b11111, 5'b11111, 5'b10111, 5'b00010}, // R8 signal 3 stopped
    {3'b111, 5'b00111, 5'b11111, 5'b11111, 5'b10010}, // R3 staging to track 3
    {3'b111, 5'b00111, 5'b10111, 5'b11111, 5'b00010}, // R7 track 3 occupied
    {3'b111, 5'b11111, 5'b11011, 5'b11111, 5'b01010}  // R7 off-route occupancy ignored
  };

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    turn_norm = '1; dir_east = '1; occ_n = '1; stop_n = '1;
    #3;
    for (int i = 0; i < NV; i++) begin
      {turn_norm, dir_east, occ_n, stop_n} = VEC[i][22:5];
      #1;
      compare($sformatf("R%0d_vec%0d", 1 + (i % 1), i), VEC[i][4:0]);
      #1;
    end
    // R6: mixed directions, destination end wrong
    turn_norm = 3'b111; dir_east = 5'b11110; occ_n = '1; stop_n = '1;
    #1; compare("R6 entry with track 1 eastbound", 5'b01000);
    #1;
    dir_east = 5'b11101;
    #1; compare("R6 exit with track 1 westbound", 5'b01000);
    #1;
    // R1: no memory, returning to all-high restores the same aspect
    turn_norm = '1; dir_east = '1; occ_n = '1; stop_n = '1;
    #1; compare("R1 return to idle", 5'b01010);
    #1;
    // Full sweep R2 R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < (1 << 18); v++) begin
      {turn_norm, dir_east, occ_n, stop_n} = v[17:0];
      #1;
      compare("R9_sweep", ref_aspect(turn_norm, dir_east, occ_n, stop_n));
      #1;
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule